// File: doc/BRIEF.md
# Mailbox Interrupt Controller

This block produces the doorbell interrupts between the two ports of a shared two-port memory. It reserves the top two word addresses of the memory as mailboxes. The all-ones word belongs to the right port, and the word one below it belongs to the left port. The block watches each port's access signals. When one port writes into the other port's mailbox word, the interrupt of the owning port is raised. When the owning port then reads its own mailbox word, that interrupt is dropped. The message itself lives in the ordinary memory. This block only keeps the two pending flags.

Each port supplies an enable, a write strobe, a read strobe, an address and a busy indication from the collision arbiter. A port whose busy is active can neither raise the other side's interrupt nor drop its own. Both interrupt outputs are active low. Each one is registered and follows the qualifying access by one clock.

Top module: `mbox_irq`

## Requirements
- R1: After reset, both `l_irq_n` and `r_irq_n` are high (no interrupt pending).
- R2: A left write with `l_en`=1, `l_wr`=1, `l_busy`=0 and `l_addr` all ones drives `r_irq_n` low after the next rising clock edge.
- R3: A right write with `r_en`=1, `r_wr`=1, `r_busy`=0 and `r_addr` equal to all ones minus one drives `l_irq_n` low after the next rising clock edge.
- R4: A read by a port of its own mailbox drives that port's interrupt high after the next edge. The port's enable and read strobe must be 1 and its busy must be 0. The right port's mailbox is all ones and the left port's is all ones minus one.
- R5: A port reading the other port's mailbox address leaves both interrupts unchanged.
- R6: A mailbox write made while the writing port's busy is 1 leaves the target interrupt unchanged.
- R7: An own-mailbox read made while the reading port's busy is 1 leaves that port's interrupt unchanged.
- R8: When a qualifying set and a qualifying clear of the same interrupt occur in the same cycle, the interrupt ends up asserted (low).
- R9: Writes to addresses other than the mailbox word, and strobes made with the port's enable at 0, change neither interrupt.
- R10: The mailbox addresses follow the `ADDR_W` parameter. With `ADDR_W`=13, a write to 0x0FFF does not set `r_irq_n`, while a write to 0x1FFF does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| l_en | input | 1 | Left port access enable |
| l_wr | input | 1 | Left port write strobe |
| l_rd | input | 1 | Left port read strobe |
| l_addr | input | ADDR_W | Left port word address |
| l_busy | input | 1 | Left port lost arbitration |
| r_en | input | 1 | Right port access enable |
| r_wr | input | 1 | Right port write strobe |
| r_rd | input | 1 | Right port read strobe |
| r_addr | input | ADDR_W | Right port word address |
| r_busy | input | 1 | Right port lost arbitration |
| l_irq_n | output | 1 | Left port interrupt, active low |
| r_irq_n | output | 1 | Right port interrupt, active low |

## Verification
The bench sets each interrupt with a qualifying write and clears it with an owner read. It then repeats those same accesses with busy raised, which shows whether the busy gating applies to the set path, the clear path, or both. Reads of the other port's mailbox, writes to a neighbouring address and strobes with the enable low separate an exact address and enable decode from a loose one. A simultaneous set and clear checks the priority order. A 13-bit instance checks that the mailbox decode follows the parameter and is not tied to a fixed 12-bit value.

// File: rtl/mbox_irq.sv
module mbox_irq #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_en,
  input  logic              l_wr,
  input  logic              l_rd,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_busy,
  input  logic              r_en,
  input  logic              r_wr,
  input  logic              r_rd,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_busy,
  output logic              l_irq_n,
  output logic              r_irq_n
);
  localparam logic [ADDR_W-1:0] R_BOX = '1;
  localparam logic [ADDR_W-1:0] L_BOX = R_BOX - 1'b1;

  logic l_go, r_go;
  logic set_r, clr_r, set_l, clr_l;
  logic pend_l, pend_r;

  assign l_go  = l_en & ~l_busy;
  assign r_go  = r_en & ~r_busy;

  assign set_r = l_go & l_wr & (l_addr == R_BOX);
  assign clr_r = r_go & r_rd & (r_addr == R_BOX);
  assign set_l = r_go & r_wr & (r_addr == L_BOX);
  assign clr_l = l_go & l_rd & (l_addr == L_BOX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_l <= 1'b0;
      pend_r <= 1'b0;
    end else begin
      if (set_l)      pend_l <= 1'b1;
      else if (clr_l) pend_l <= 1'b0;
      if (set_r)      pend_r <= 1'b1;
      else if (clr_r) pend_r <= 1'b0;
    end
  end

  assign l_irq_n = ~pend_l;
  assign r_irq_n = ~pend_r;
endmodule

// File: rtl/mbox_irq_chk.sv
module mbox_irq_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              l_en,
  input logic              l_wr,
  input logic              l_rd,
  input logic [ADDR_W-1:0] l_addr,
  input logic              l_busy,
  input logic              r_en,
  input logic              r_wr,
  input logic              r_rd,
  input logic [ADDR_W-1:0] r_addr,
  input logic              r_busy,
  input logic              l_irq_n,
  input logic              r_irq_n
);
  localparam logic [ADDR_W-1:0] TOPW = '1;
  localparam logic [ADDR_W-1:0] NXTW = TOPW - 1'b1;

  assert_left_sets_right_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (l_en && l_wr && !l_busy && l_addr == TOPW) |=> !r_irq_n);

  assert_right_sets_left_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (r_en && r_wr && !r_busy && r_addr == NXTW) |=> !l_irq_n);

  assert_owner_clears_right_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (r_en && r_rd && !r_busy && r_addr == TOPW &&
     !(l_en && l_wr && !l_busy && l_addr == TOPW)) |=> r_irq_n);

  assert_owner_clears_left_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (l_en && l_rd && !l_busy && l_addr == NXTW &&
     !(r_en && r_wr && !r_busy && r_addr == NXTW)) |=> l_irq_n);

  assert_only_write_sets_right_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (r_irq_n && !(l_en && l_wr && !l_busy && l_addr == TOPW)) |=> r_irq_n);

  assert_only_write_sets_left_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (l_irq_n && !(r_en && r_wr && !r_busy && r_addr == NXTW)) |=> l_irq_n);

  assert_only_read_clears_right_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_irq_n && !(r_en && r_rd && !r_busy && r_addr == TOPW)) |=> !r_irq_n);

  assert_only_read_clears_left_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_irq_n && !(l_en && l_rd && !l_busy && l_addr == NXTW)) |=> !l_irq_n);
endmodule

bind mbox_irq mbox_irq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/mbox_irq_tb.sv
`timescale 1ns/1ps
module mbox_irq_tb;
  localparam int AW = 12;
  localparam logic [AW-1:0] TOP = '1;
  localparam logic [AW-1:0] NXT = TOP - 1'b1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_en = 0, l_wr = 0, l_rd = 0, l_busy = 0;
  logic r_en = 0, r_wr = 0, r_rd = 0, r_busy = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_irq_n, r_irq_n;

  logic w_en = 0, w_wr = 0;
  logic [12:0] w_addr = '0;
  logic w_lirq, w_rirq;

  int tests = 0;
  int fails = 0;
  bit   q_l[$];
  bit   q_r[$];
  string q_t[$];

  always #5 clk = ~clk;

  mbox_irq #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .l_en(l_en), .l_wr(l_wr), .l_rd(l_rd), .l_addr(l_addr), .l_busy(l_busy),
    .r_en(r_en), .r_wr(r_wr), .r_rd(r_rd), .r_addr(r_addr), .r_busy(r_busy),
    .l_irq_n(l_irq_n), .r_irq_n(r_irq_n));

  mbox_irq #(.ADDR_W(13)) u_dut13 (
    .clk(clk), .rst_n(rst_n),
    .l_en(w_en), .l_wr(w_wr), .l_rd(1'b0), .l_addr(w_addr), .l_busy(1'b0),
    .r_en(1'b0), .r_wr(1'b0), .r_rd(1'b0), .r_addr(13'd0), .r_busy(1'b0),
    .l_irq_n(w_lirq), .r_irq_n(w_rirq));

  task automatic check(input string tag, input bit act_l, act_r, exp_l, exp_r);
    tests++;
    if (act_l !== exp_l || act_r !== exp_r) begin
      fails++;
      $display("FAIL %s: l_irq_n/r_irq_n = %b/%b, expected %b/%b", tag, act_l, act_r, exp_l, exp_r);
    end
  endtask

  task automatic acc(input bit le, lw, lr, input logic [AW-1:0] la, input bit lb,
                     input bit re, rw, rr, input logic [AW-1:0] ra, input bit rb,
                     input bit exp_l, exp_r, input string tag);
    @(negedge clk);
    l_en = le; l_wr = lw; l_rd = lr; l_addr = la; l_busy = lb;
    r_en = re; r_wr = rw; r_rd = rr; r_addr = ra; r_busy = rb;
    q_l.push_back(exp_l); q_r.push_back(exp_r); q_t.push_back(tag);
  endtask

  always @(posedge clk) begin
    #2;
    if (q_l.size() > 0) begin
      automatic bit    el = q_l.pop_front();
      automatic bit    er = q_r.pop_front();
      automatic string t  = q_t.pop_front();
      check(t, l_irq_n, r_irq_n, el, er);
    end
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset state", l_irq_n, r_irq_n, 1, 1);
    check("R1 reset state 13-bit", w_lirq, w_rirq, 1, 1);
    @(negedge clk); rst_n = 1'b1;

    acc(1,1,0,TOP,0, 0,0,0,0,0,   1,0, "R2 left write sets right");
    acc(1,0,1,TOP,0, 0,0,0,0,0,   1,0, "R5 left reads right box");
    acc(0,0,0,0,0,   1,0,1,NXT,0, 1,0, "R5 right reads left box");
    acc(0,0,0,0,0,   1,0,1,TOP,1, 1,0, "R7 busy right read keeps");
    acc(0,0,0,0,0,   1,0,1,TOP,0, 1,1, "R4 right owner read clears");
    acc(1,1,0,TOP,1, 0,0,0,0,0,   1,1, "R6 busy left write blocked");
    acc(0,0,0,0,0,   1,1,0,NXT,0, 0,1, "R3 right write sets left");
    acc(1,0,1,NXT,1, 0,0,0,0,0,   0,1, "R7 busy left read keeps");
    acc(1,0,1,NXT,0, 0,0,0,0,0,   1,1, "R4 left owner read clears");
    acc(0,0,0,0,0,   1,1,0,NXT,1, 1,1, "R6 busy right write blocked");
    acc(1,1,0,TOP-2'd2,0, 1,1,0,TOP-2'd2,0, 1,1, "R9 neighbour address ignored");
    acc(0,1,0,TOP,0, 0,1,0,NXT,0, 1,1, "R9 disabled strobe ignored");
    acc(1,1,0,TOP,0, 1,0,1,TOP,0, 1,0, "R8 right set beats clear");
    acc(1,0,1,NXT,0, 1,1,0,NXT,0, 0,0, "R8 left set beats clear");
    acc(1,0,1,NXT,0, 1,0,1,TOP,0, 1,1, "R4 both owners clear");
    acc(0,0,0,0,0,   0,0,0,0,0,   1,1, "R9 idle holds");
    repeat (3) @(negedge clk);

    w_en = 1; w_wr = 1; w_addr = 13'h0FFF;
    @(posedge clk); #2;
    check("R10 13-bit low top ignored", w_lirq, w_rirq, 1, 1);
    @(negedge clk); w_addr = 13'h1FFF;
    @(posedge clk); #2;
    check("R10 13-bit top sets right", w_lirq, w_rirq, 1, 0);
    @(negedge clk); w_en = 0; w_wr = 0;

    repeat (2) @(negedge clk);
    tests++;
    if (q_l.size() != 0) begin
      fails++;
      $display("FAIL scoreboard: %0d items left, expected 0", q_l.size());
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule